// File: doc/BRIEF.md
# Codec-side serial audio link framer

This block sits at the codec end of a 48 kHz serial audio link made of five wires: a bit clock, a frame marker (SYNC), a data stream from the controller, a data stream back to the controller, and an active-low reset. It runs on the internal bit-rate clock. It tells the pad logic when the outgoing bit clock may toggle (`bclk_run_o`) and when the pads may drive at all (`link_oe_o`).

The block locates each frame at the rising edge of SYNC. It shifts in the tag slot and the first two command slots, most significant bit first. It turns a valid write into a one-cycle strobe on a small register bus. It turns a valid read into a read strobe, then returns the fetched value in the tag, slot 1 and slot 2 of the following frame. Register storage lives outside the block.

The block also sequences the link through four conditions:
- a cold reset;
- an optional high-impedance test state, chosen by the level of the controller's data line just after reset;
- a link shutdown triggered by a power-control register write;
- a wake-up when SYNC is held high for a long pulse while the link is down.

Top module: `acl_codec_link`

## Requirements
- R1: While `rst_ni` is low, `bclk_run_o` and `sdi_o` are 0 and `link_oe_o` is 1. After release with `sdo_i` low, `bclk_run_o` rises on the RESTART_CYC-th clock edge and not before.
- R2: If `sdo_i` is high at the first clock edge after reset release, `link_oe_o` goes to 0 (high impedance) and stays 0 with `bclk_run_o` at 0. Frames are ignored until the next cold reset.
- R3: A frame starts on the first clock at which SYNC is sampled high after being low; that cycle's `sdo_i` is tag bit 15. A write needs tag bits 15 (frame valid), 14 (slot 1 valid) and 13 (slot 2 valid) set, and slot 1 bit 19 = 0. It gives exactly one `reg_we_o` pulse, with index = slot 1 bits 18:12 and data = slot 2 bits 19:4.
- R4: Writes to an odd index produce no strobe and leave the register bus unwritten.
- R5: A read needs tag bits 15 and 14 set and slot 1 bit 19 = 1. For an even index it pulses `reg_re_o`. The next frame returns tag 0xE000 (bit 15 codec ready, bits 14 and 13 slot valid), slot 1 = index in bits 18:12, and slot 2 = data in bits 19:4.
- R6: A read of an odd index pulses no strobe and returns data 0. The index is still echoed.
- R7: A command whose required tag bits are not all set has no effect on the register bus and produces no response.
- R8: A write to index 0x26 with data bit 12 set is performed. From the following clock edge, `bclk_run_o` and `sdi_o` are 0.
- R9: While the link is down, no strobes occur, `sdo_i` activity is ignored, and a SYNC pulse shorter than WARM_MIN cycles does not wake the link.
- R10: While the link is down, a SYNC pulse of at least WARM_MIN cycles wakes it. `bclk_run_o` rises on the RESTART_CYC-th edge after the first edge that sees SYNC low again.
- R11: While running, a frame after one with no accepted read returns tag 0x8000 and zero slots 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal bit-rate clock |
| rst_ni | input | 1 | Cold reset, active low |
| sync_i | input | 1 | Frame marker from controller |
| sdo_i | input | 1 | Serial data from controller |
| sdi_o | output | 1 | Serial data to controller |
| bclk_run_o | output | 1 | Outgoing bit clock enable (0 = held low) |
| link_oe_o | output | 1 | Pad drive enable (0 = high impedance) |
| reg_addr_o | output | IDX_W | Register index |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | DATA_W | Register read data, sampled with `reg_re_o` |

## Verification
The bench builds the block with three data slots per frame (a 76-bit frame), WARM_MIN of 4 and RESTART_CYC of 3. With a frame that short, writing and then reading back every one of the 128 register indices is affordable, so each odd/even case is covered. The small wake and restart counts make the cycle-exact edges of cold restart, warm wake-up and a too-short SYNC pulse cheap to pin down. Shutdown, test-mode entry and invalid tag combinations are each driven on top of that sweep.

// File: rtl/acl_pkg.sv
package acl_pkg;
    typedef enum logic [1:0] {
        LS_WAIT = 2'd0,
        LS_RUN  = 2'd1,
        LS_DOWN = 2'd2,
        LS_TEST = 2'd3
    } link_state_e;
endpackage

// File: rtl/acl_power_seq.sv
module acl_power_seq #(
    parameter int WARM_MIN    = 12,
    parameter int RESTART_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    input  logic sdo_i,
    input  logic pd_req_i,
    output logic run_o,
    output logic oe_o
);
    import acl_pkg::*;

    localparam int MAXC = (WARM_MIN > RESTART_CYC) ? WARM_MIN : RESTART_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        link_state_e   state;
        logic          first;
        logic [CW-1:0] cnt;
        logic [CW-1:0] hi;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        d.first = 1'b0;
        case (q.state)
            LS_WAIT: begin
                if (q.first && sdo_i) begin
                    d.state = LS_TEST;
                end else if (q.cnt == CW'(RESTART_CYC - 1)) begin
                    d.state = LS_RUN;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            LS_RUN: begin
                if (pd_req_i) begin
                    d.state = LS_DOWN;
                    d.hi    = '0;
                end
            end
            LS_DOWN: begin
                if (sync_i) begin
                    if (q.hi < CW'(WARM_MIN)) d.hi = q.hi + 1'b1;
                end else if (q.hi >= CW'(WARM_MIN)) begin
                    d.state = LS_WAIT;
                    d.cnt   = '0;
                    d.hi    = '0;
                end else begin
                    d.hi = '0;
                end
            end
            default: d.state = LS_TEST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= LS_WAIT;
            q.first <= 1'b1;
            q.cnt   <= '0;
            q.hi    <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_o = (q.state == LS_RUN);
    assign oe_o  = (q.state != LS_TEST);
endmodule

// File: rtl/acl_frame_rx.sv
module acl_frame_rx #(
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int NUM_SLOTS = 12,
    parameter int IDX_W     = 7,
    parameter int DATA_W    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              sync_i,
    input  logic              sdo_i,
    output logic              start_o,
    output logic              cmd_vld_o,
    output logic              cmd_rd_o,
    output logic [IDX_W-1:0]  cmd_idx_o,
    output logic [DATA_W-1:0] cmd_data_o
);
    localparam int FRAME_BITS = TAG_BITS + SLOT_BITS * NUM_SLOTS;
    localparam int CMD_BITS   = TAG_BITS + 2 * SLOT_BITS;
    localparam int CW         = $clog2(FRAME_BITS + 1);
    localparam int S1_TOP     = 2 * SLOT_BITS - 1;
    localparam int S2_TOP     = SLOT_BITS - 1;

    typedef struct packed {
        logic                sync_prev;
        logic                in_frame;
        logic [CW-1:0]       pos;
        logic [CMD_BITS-2:0] sr;
        logic                vld;
        logic                rd;
        logic [IDX_W-1:0]    idx;
        logic [DATA_W-1:0]   data;
    } rx_t;

    rx_t q, d;
    logic [CMD_BITS-1:0] full;
    logic                start;
    logic                tag_frame, tag_s1, tag_s2, is_rd;

    assign full      = {q.sr, sdo_i};
    assign start     = run_i && sync_i && !q.sync_prev;
    assign tag_frame = full[CMD_BITS-1];
    assign tag_s1    = full[CMD_BITS-2];
    assign tag_s2    = full[CMD_BITS-3];
    assign is_rd     = full[S1_TOP];

    always_comb begin
        d           = q;
        d.sync_prev = sync_i;
        d.vld       = 1'b0;
        if (!run_i) begin
            d.in_frame = 1'b0;
            d.pos      = '0;
        end else if (start) begin
            d.in_frame = 1'b1;
            d.pos      = CW'(1);
            d.sr       = {{(CMD_BITS-2){1'b0}}, sdo_i};
        end else if (q.in_frame) begin
            d.sr = full[CMD_BITS-2:0];
            if (q.pos < CW'(FRAME_BITS)) d.pos = q.pos + 1'b1;
            if (q.pos == CW'(CMD_BITS - 1)) begin
                d.vld  = tag_frame && tag_s1 && (is_rd || tag_s2);
                d.rd   = is_rd;
                d.idx  = full[S1_TOP-1 -: IDX_W];
                d.data = full[S2_TOP -: DATA_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_o    = start;
    assign cmd_vld_o  = q.vld;
    assign cmd_rd_o   = q.rd;
    assign cmd_idx_o  = q.idx;
    assign cmd_data_o = q.data;
endmodule

// File: rtl/acl_frame_tx.sv
module acl_frame_tx #(
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int IDX_W     = 7,
    parameter int DATA_W    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              start_i,
    input  logic              rd_vld_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              sdi_o
);
    localparam int CMD_BITS = TAG_BITS + 2 * SLOT_BITS;
    localparam int S1_PAD   = SLOT_BITS - 1 - IDX_W;
    localparam int S2_PAD   = SLOT_BITS - DATA_W;

    typedef struct packed {
        logic                pend;
        logic [IDX_W-1:0]    pidx;
        logic [DATA_W-1:0]   pdata;
        logic [CMD_BITS-2:0] sr;
        logic                sdi;
    } tx_t;

    tx_t q, d;
    logic [CMD_BITS-1:0] load;
    logic [IDX_W-1:0]    echo_idx;
    logic [DATA_W-1:0]   echo_data;

    assign echo_idx  = q.pend ? q.pidx  : '0;
    assign echo_data = q.pend ? q.pdata : '0;
    assign load = {1'b1, q.pend, q.pend, {(TAG_BITS-3){1'b0}},
                   1'b0, echo_idx, {S1_PAD{1'b0}},
                   echo_data, {S2_PAD{1'b0}}};

    always_comb begin
        d = q;
        if (!run_i) begin
            d = '0;
        end else begin
            if (start_i) begin
                d.sdi  = load[CMD_BITS-1];
                d.sr   = load[CMD_BITS-2:0];
                d.pend = 1'b0;
            end else begin
                d.sdi = q.sr[CMD_BITS-2];
                d.sr  = {q.sr[CMD_BITS-3:0], 1'b0};
            end
            if (rd_vld_i) begin
                d.pend  = 1'b1;
                d.pidx  = idx_i;
                d.pdata = idx_i[0] ? '0 : rdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdi_o = q.sdi;
endmodule

// File: rtl/acl_codec_link.sv
module acl_codec_link #(
    parameter int TAG_BITS    = 16,
    parameter int SLOT_BITS   = 20,
    parameter int NUM_SLOTS   = 12,
    parameter int IDX_W       = 7,
    parameter int DATA_W      = 16,
    parameter int WARM_MIN    = 12,
    parameter int RESTART_CYC = 2,
    parameter int PD_IDX      = 'h26,
    parameter int PD_BIT      = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sync_i,
    input  logic              sdo_i,
    output logic              sdi_o,
    output logic              bclk_run_o,
    output logic              link_oe_o,
    output logic [IDX_W-1:0]  reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    logic              run, oe, start, pd_req, sdi_raw;
    logic              cmd_vld, cmd_rd;
    logic [IDX_W-1:0]  cmd_idx;
    logic [DATA_W-1:0] cmd_data;
    logic              we, re;

    assign we     = cmd_vld && !cmd_rd && !cmd_idx[0];
    assign re     = cmd_vld &&  cmd_rd && !cmd_idx[0];
    assign pd_req = we && (cmd_idx == IDX_W'(PD_IDX)) && cmd_data[PD_BIT];

    acl_power_seq #(
        .WARM_MIN    (WARM_MIN),
        .RESTART_CYC (RESTART_CYC)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sync_i   (sync_i),
        .sdo_i    (sdo_i),
        .pd_req_i (pd_req),
        .run_o    (run),
        .oe_o     (oe)
    );

    acl_frame_rx #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W),
        .DATA_W    (DATA_W)
    ) u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .sync_i     (sync_i),
        .sdo_i      (sdo_i),
        .start_o    (start),
        .cmd_vld_o  (cmd_vld),
        .cmd_rd_o   (cmd_rd),
        .cmd_idx_o  (cmd_idx),
        .cmd_data_o (cmd_data)
    );

    acl_frame_tx #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .IDX_W     (IDX_W),
        .DATA_W    (DATA_W)
    ) u_tx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run),
        .start_i  (start),
        .rd_vld_i (cmd_vld && cmd_rd),
        .idx_i    (cmd_idx),
        .rdata_i  (reg_rdata_i),
        .sdi_o    (sdi_raw)
    );

    assign sdi_o       = sdi_raw && run;
    assign bclk_run_o  = run;
    assign link_oe_o   = oe;
    assign reg_addr_o  = cmd_idx;
    assign reg_wdata_o = cmd_data;
    assign reg_we_o    = we;
    assign reg_re_o    = re;
endmodule

// File: rtl/acl_codec_link_chk.sv
module acl_codec_link_chk #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16,
    parameter int PD_IDX = 'h26,
    parameter int PD_BIT = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sdi_o,
    input logic              bclk_run_o,
    input logic              link_oe_o,
    input logic [IDX_W-1:0]  reg_addr_o,
    input logic [DATA_W-1:0] reg_wdata_o,
    input logic              reg_we_o,
    input logic              reg_re_o
);
    a_r4_write_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_o |-> !reg_addr_o[0]);

    a_r6_read_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_re_o |-> !reg_addr_o[0]);

    a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_o |=> !reg_we_o);

    a_r5_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_we_o && reg_re_o));

    a_r8_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_o && reg_addr_o == IDX_W'(PD_IDX) && reg_wdata_o[PD_BIT])
        |=> (!bclk_run_o && !sdi_o));

    a_r2_hiz_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !link_oe_o |=> !link_oe_o);

    a_r2_hiz_no_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !link_oe_o |-> !bclk_run_o);

    a_r9_no_strobe_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bclk_run_o |-> !(reg_we_o || reg_re_o));
endmodule

bind acl_codec_link acl_codec_link_chk #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .PD_IDX (PD_IDX),
    .PD_BIT (PD_BIT)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sdi_o       (sdi_o),
    .bclk_run_o  (bclk_run_o),
    .link_oe_o   (link_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o)
);

// File: tb/test_acl_codec_link.sv
module test_acl_codec_link;
    localparam int CLK_P   = 10;
    localparam int NSLOT   = 3;
    localparam int WMIN    = 4;
    localparam int RCYC    = 3;
    localparam int FB      = 16 + 20 * NSLOT;
    localparam int CB      = 56;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        sdo = 1'b0;
    logic        sdi, run, oe, we, re;
    logic [6:0]  addr;
    logic [15:0] wdata, rdata;
    logic [15:0] mem [128];
    int          we_cnt = 0;
    int          re_cnt = 0;
    int          nchk = 0;
    int          nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    acl_codec_link #(
        .NUM_SLOTS   (NSLOT),
        .WARM_MIN    (WMIN),
        .RESTART_CYC (RCYC)
    ) i_acl_codec_link (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sync_i      (sync),
        .sdo_i       (sdo),
        .sdi_o       (sdi),
        .bclk_run_o  (run),
        .link_oe_o   (oe),
        .reg_addr_o  (addr),
        .reg_wdata_o (wdata),
        .reg_we_o    (we),
        .reg_re_o    (re),
        .reg_rdata_i (rdata)
    );

    assign rdata = mem[addr];

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = (i % 2 == 1) ? 16'hFFFF : 16'h0000;
    end

    always @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
            we_cnt <= we_cnt + 1;
        end
        if (re) re_cnt <= re_cnt + 1;
    end

    function automatic logic [15:0] patt(input int i);
        return ((16'(i) * 16'h0911) ^ 16'hA5C3) & 16'hEFFF;
    endfunction

    function automatic logic [55:0] mk(input logic [15:0] tag, input logic rdf,
                                       input logic [6:0] idx, input logic [15:0] dat);
        return {tag, rdf, idx, 12'h000, dat, 4'h0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [55:0] cmd, output logic [55:0] resp);
        resp = '0;
        for (int b = 0; b < FB; b++) begin
            @(negedge clk);
            if (b > 0 && b <= CB) resp[CB-b] = sdi;
            sync = (b < 16);
            sdo  = (b < CB) ? cmd[CB-1-b] : 1'b0;
        end
    endtask

    task automatic cold_reset(input logic sdo_lvl);
        @(negedge clk);
        rst_n = 1'b0;
        sync  = 1'b0;
        sdo   = sdo_lvl;
        repeat (8) @(negedge clk);
        chk("R1 run in reset", 64'(run), 64'(0));
        chk("R1 sdi in reset", 64'(sdi), 64'(0));
        chk("R1 oe in reset", 64'(oe), 64'(1));
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [55:0] r;
        int we0, re0;

        // R1: cold restart timing
        cold_reset(1'b0);
        repeat (RCYC - 1) @(negedge clk);
        chk("R1 run before restart", 64'(run), 64'(0));
        @(negedge clk);
        chk("R1 run after restart", 64'(run), 64'(1));

        // R11: idle frame
        send_frame('0, r);
        send_frame('0, r);
        chk("R11 idle response", 64'(r), 64'({16'h8000, 40'h0}));

        // R3/R4: write sweep
        for (int i = 0; i < 128; i++) send_frame(mk(16'hE000, 1'b0, 7'(i), patt(i)), r);
        send_frame('0, r);
        chk("R4 write strobe count", 64'(we_cnt), 64'(64));
        for (int i = 0; i < 128; i++) begin
            if (i % 2 == 0) chk("R3 written value", 64'(mem[i]), 64'(patt(i)));
            else            chk("R4 odd entry untouched", 64'(mem[i]), 64'(16'hFFFF));
        end

        // R5/R6: read sweep, response one frame later
        re0 = re_cnt;
        for (int j = 0; j <= 128; j++) begin
            send_frame((j < 128) ? mk(16'hC000, 1'b1, 7'(j), 16'h0) : 56'h0, r);
            if (j > 0) begin
                chk("R5 tag and index echo", 64'(r[55:20]),
                    64'({16'hE000, 1'b0, 7'(j-1), 12'h000}));
                if ((j - 1) % 2 == 0)
                    chk("R5 read data", 64'(r[19:0]), 64'({patt(j-1), 4'h0}));
                else
                    chk("R6 odd read zero", 64'(r[19:0]), 64'(0));
            end
        end
        chk("R6 read strobe count", 64'(re_cnt - re0), 64'(64));

        // R7: invalid tag combinations
        we0 = we_cnt;
        re0 = re_cnt;
        send_frame(mk(16'h6000, 1'b0, 7'd2, 16'h1234), r);
        send_frame(mk(16'hC000, 1'b0, 7'd2, 16'h1234), r);
        send_frame(mk(16'h8000, 1'b1, 7'd2, 16'h0), r);
        send_frame('0, r);
        chk("R7 no write strobe", 64'(we_cnt - we0), 64'(0));
        chk("R7 value kept", 64'(mem[2]), 64'(patt(2)));
        chk("R7 no read strobe", 64'(re_cnt - re0), 64'(0));
        chk("R7 no response", 64'(r), 64'({16'h8000, 40'h0}));

        // R8: shutdown write
        send_frame(mk(16'hE000, 1'b0, 7'h26, 16'h1000), r);
        chk("R8 run stopped", 64'(run), 64'(0));
        chk("R8 sdi low", 64'(sdi), 64'(0));
        chk("R8 write performed", 64'(mem[7'h26]), 64'(16'h1000));

        // R9: activity while down, short SYNC pulse
        we0 = we_cnt;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            sdo = k[0];
        end
        sdo  = 1'b0;
        sync = 1'b1;
        repeat (WMIN - 1) @(negedge clk);
        sync = 1'b0;
        repeat (12) @(negedge clk);
        chk("R9 short pulse keeps down", 64'(run), 64'(0));
        chk("R9 no strobe while down", 64'(we_cnt - we0), 64'(0));

        // R10: warm wake-up
        sync = 1'b1;
        repeat (WMIN) @(negedge clk);
        sync = 1'b0;
        repeat (RCYC) @(negedge clk);
        chk("R10 run before restart", 64'(run), 64'(0));
        @(negedge clk);
        chk("R10 run after restart", 64'(run), 64'(1));
        send_frame(mk(16'hC000, 1'b1, 7'h26, 16'h0), r);
        send_frame('0, r);
        chk("R10 ready after wake", 64'(r[55:40]), 64'(16'hE000));
        chk("R10 data after wake", 64'(r[19:4]), 64'(16'h1000));

        // R2: test mode entry
        cold_reset(1'b1);
        @(negedge clk);
        chk("R2 high impedance", 64'(oe), 64'(0));
        sdo = 1'b0;
        re0 = re_cnt;
        send_frame(mk(16'hC000, 1'b1, 7'd0, 16'h0), r);
        send_frame('0, r);
        chk("R2 hiz held", 64'(oe), 64'(0));
        chk("R2 clock held", 64'(run), 64'(0));
        chk("R2 frames ignored", 64'(re_cnt - re0), 64'(0));

        // R1: cold reset leaves test mode
        cold_reset(1'b0);
        repeat (RCYC) @(negedge clk);
        chk("R1 oe restored", 64'(oe), 64'(1));
        chk("R1 run restored", 64'(run), 64'(1));

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule